// File: doc/BRIEF.md
# Low-Power Stop Entry Sequencer

This block announces on the system bus that the processor is about to enter a low-power stop state. A stop request makes it wait until the bus is free. It then drives a visible write cycle in the processor's special (CPU) address space. That cycle carries the current interrupt mask level, so that any agent on the bus can see that the core is going quiet and which interrupt levels can still wake it. The block ends that cycle with its own acknowledge. No external device has to respond.

An external agent can postpone entry by asserting a halt input. Halt passes through a two-flop synchronizer. If the synchronized halt is high when the announcing cycle ends, the sequencer waits until it falls and only then raises its stopped flag. A wake input returns the block from the stopped state to idle. A synchronous active-high reset forces idle from any state.

Top module: `lpstop_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `cyc_strobe`, `cyc_ack`, `cyc_write` and `stopped` are 0, and `cyc_addr`, `cyc_fc` and `cyc_data` are all zero.
- R2: After `stop_req` is seen in idle, no cycle is driven for as long as `bus_free` stays low.
- R3: `cyc_strobe` and `cyc_write` rise on the clock after the edge that samples `bus_free` high in the waiting state. They stay high for exactly `DRIVE_LEN` cycles (default 2). Throughout those cycles `cyc_fc` is 3'b111, `cyc_addr[19:16]` is 4'b0011, and all other address bits are 0.
- R4: During the cycle, `cyc_data[2:0]` holds the `mask_lvl` value sampled at the edge where `bus_free` was taken. The upper data bits are 0. The data stays stable however `mask_lvl` changes afterwards.
- R5: `cyc_ack` is 1 exactly in the last strobe cycle and 0 at every other time.
- R6: `halt` passes through two flops. If the synchronized halt is high at the edge that ends the cycle, `stopped` stays 0 while halt is held. `stopped` rises at the third rising edge after `halt` falls.
- R7: Without halt, `stopped` is 1 in the cycle right after the last strobe cycle.
- R8: While `stopped` is 1, the bus outputs stay idle and a new `stop_req` has no effect.
- R9: `wake` in the stopped state clears `stopped` at the next edge and returns to idle. `wake` in any other state is ignored.
- R10: Reset in the middle of the announcing cycle drops `cyc_strobe` at the next edge, and the next request runs a full, normal sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Request to enter the stop state (taken in idle) |
| mask_lvl | input | 3 | Current interrupt mask level |
| bus_free | input | 1 | Bus is available for this block's cycle |
| halt | input | 1 | Asynchronous hold-off of stop entry |
| wake | input | 1 | Leave the stopped state |
| cyc_addr | output | ADDR_W | Address of the announcing cycle |
| cyc_fc | output | 3 | Address-space code of the cycle |
| cyc_data | output | DATA_W | Write data (mask level in bits 2:0) |
| cyc_strobe | output | 1 | Cycle strobe |
| cyc_write | output | 1 | Write direction of the cycle |
| cyc_ack | output | 1 | Internally generated cycle acknowledge |
| stopped | output | 1 | Stop state reached |

## Verification
The hardest case to reach is the halt release edge. Halt must already be through the synchronizer when the cycle ends, and then released at a known cycle, so that the three-edge latency of R6 can be checked exactly. The stimulus raises halt before the stop request, holds it for a random number of cycles after the acknowledge, and checks `stopped` on each edge around the release. Random bus delays and a mask input that changes as soon as the bus is taken exercise the capture rule of R4.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_BUS  = 3'd1,
        ST_DRIVE     = 3'd2,
        ST_HALT_HOLD = 3'd3,
        ST_STOPPED   = 3'd4
    } lp_state_e;

    // Special address space code and the cycle type that marks stop entry
    localparam logic [2:0] FC_SPECIAL    = 3'b111;
    localparam logic [3:0] TYPE_STOP     = 4'd3;
    localparam int         TYPE_LSB      = 16;
    localparam int         MASK_W        = 3;

    typedef struct packed {
        logic       strobe;
        logic       write;
        logic [2:0] fc;
    } cyc_ctl_t;

    function automatic logic [31:0] stop_addr_word();
        return 32'(TYPE_STOP) << TYPE_LSB;
    endfunction

    function automatic logic [31:0] stop_data_word(input logic [MASK_W-1:0] lvl);
        return {{(32-MASK_W){1'b0}}, lvl};
    endfunction

    function automatic cyc_ctl_t ctl_for(input lp_state_e st);
        cyc_ctl_t c;
        c = '0;
        if (st == ST_DRIVE) begin
            c.strobe = 1'b1;
            c.write  = 1'b1;
            c.fc     = FC_SPECIAL;
        end
        return c;
    endfunction

endpackage

// File: rtl/lpstop_sync.sv
module lpstop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/lpstop_fsm.sv
module lpstop_fsm
    import lpstop_pkg::*;
#(
    parameter int DRIVE_LEN = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      stop_req,
    input  logic      bus_free,
    input  logic      halt_s,
    input  logic      wake,
    output lp_state_e state_o,
    output logic      last_beat,
    output logic      capture
);
    localparam int CW = (DRIVE_LEN > 1) ? $clog2(DRIVE_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(DRIVE_LEN - 1);

    lp_state_e state_q, state_d;
    logic [CW-1:0] beat_q;

    assign last_beat = (state_q == ST_DRIVE) && (beat_q == LAST);
    assign capture   = (state_q == ST_WAIT_BUS) && bus_free;
    assign state_o   = state_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:      if (stop_req) state_d = ST_WAIT_BUS;
            ST_WAIT_BUS:  if (bus_free) state_d = ST_DRIVE;
            ST_DRIVE:     if (last_beat) state_d = halt_s ? ST_HALT_HOLD : ST_STOPPED;
            ST_HALT_HOLD: if (!halt_s) state_d = ST_STOPPED;
            ST_STOPPED:   if (wake) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_DRIVE && !last_beat) beat_q <= beat_q + 1'b1;
            else                                   beat_q <= '0;
        end
    end
endmodule

// File: rtl/lpstop_bus_drv.sv
module lpstop_bus_drv
    import lpstop_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [2:0]        mask_in,
    input  lp_state_e         state_i,
    input  logic              last_beat,
    output logic [ADDR_W-1:0] addr,
    output logic [2:0]        fc,
    output logic [DATA_W-1:0] data,
    output logic              strobe,
    output logic              write,
    output logic              ack
);
    logic [2:0] mask_q;
    cyc_ctl_t   ctl;

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (capture) mask_q <= mask_in;
    end

    always_comb begin
        ctl    = ctl_for(state_i);
        strobe = ctl.strobe;
        write  = ctl.write;
        fc     = ctl.fc;
        addr   = ctl.strobe ? ADDR_W'(stop_addr_word()) : '0;
        data   = ctl.strobe ? DATA_W'(stop_data_word(mask_q)) : '0;
        ack    = last_beat;
    end
endmodule

// File: rtl/lpstop_seq.sv
module lpstop_seq
    import lpstop_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int DRIVE_LEN = 2,
    parameter int SYNC_LEN  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_req,
    input  logic [2:0]        mask_lvl,
    input  logic              bus_free,
    input  logic              halt,
    input  logic              wake,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [2:0]        cyc_fc,
    output logic [DATA_W-1:0] cyc_data,
    output logic              cyc_strobe,
    output logic              cyc_write,
    output logic              cyc_ack,
    output logic              stopped
);
    logic      halt_s;
    logic      last_beat;
    logic      capture;
    lp_state_e state;

    lpstop_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst(rst), .d_in(halt), .q_out(halt_s)
    );

    lpstop_fsm #(.DRIVE_LEN(DRIVE_LEN)) u_fsm (
        .clk(clk), .rst(rst), .stop_req(stop_req), .bus_free(bus_free),
        .halt_s(halt_s), .wake(wake), .state_o(state),
        .last_beat(last_beat), .capture(capture)
    );

    lpstop_bus_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
        .clk(clk), .rst(rst), .capture(capture), .mask_in(mask_lvl),
        .state_i(state), .last_beat(last_beat),
        .addr(cyc_addr), .fc(cyc_fc), .data(cyc_data),
        .strobe(cyc_strobe), .write(cyc_write), .ack(cyc_ack)
    );

    assign stopped = (state == ST_STOPPED);
endmodule

// File: rtl/lpstop_seq_chk.sv
module lpstop_seq_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_free,
    input logic              wake,
    input logic              halt_s,
    input logic [ADDR_W-1:0] cyc_addr,
    input logic [DATA_W-1:0] cyc_data,
    input logic              cyc_strobe,
    input logic              cyc_ack,
    input logic              stopped
);
    AST_STROBE_NEEDS_BUS: assert property (@(posedge clk) disable iff (rst)
        $rose(cyc_strobe) |-> $past(bus_free)); // R2
    AST_CYCLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cyc_strobe && $past(cyc_strobe)) |-> ($stable(cyc_data) && $stable(cyc_addr))); // R4
    AST_ACK_INSIDE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cyc_ack |-> cyc_strobe); // R5
    AST_ACK_ENDS_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cyc_ack |=> !cyc_strobe); // R5
    AST_STOP_AFTER_HALT_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(stopped) |-> !$past(halt_s)); // R6
    AST_STOPPED_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
        stopped |-> !cyc_strobe); // R8
    AST_WAKE_LEAVES: assert property (@(posedge clk) disable iff (rst)
        (stopped && wake) |=> !stopped); // R9
endmodule

bind lpstop_seq lpstop_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .bus_free(bus_free), .wake(wake), .halt_s(halt_s),
    .cyc_addr(cyc_addr), .cyc_data(cyc_data), .cyc_strobe(cyc_strobe),
    .cyc_ack(cyc_ack), .stopped(stopped)
);

// File: tb/test_lpstop_seq.sv
module test_lpstop_seq;
    localparam int AW  = 24;
    localparam int DW  = 16;
    localparam int LEN = 2;

    logic          clk = 1'b0;
    logic          rst, stop_req, bus_free, halt, wake;
    logic [2:0]    mask_lvl;
    logic [AW-1:0] cyc_addr;
    logic [2:0]    cyc_fc;
    logic [DW-1:0] cyc_data;
    logic          cyc_strobe, cyc_write, cyc_ack, stopped;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lpstop_seq #(.ADDR_W(AW), .DATA_W(DW), .DRIVE_LEN(LEN)) i_lpstop_seq (
        .clk(clk), .rst(rst), .stop_req(stop_req), .mask_lvl(mask_lvl),
        .bus_free(bus_free), .halt(halt), .wake(wake),
        .cyc_addr(cyc_addr), .cyc_fc(cyc_fc), .cyc_data(cyc_data),
        .cyc_strobe(cyc_strobe), .cyc_write(cyc_write), .cyc_ack(cyc_ack),
        .stopped(stopped)
    );

    function automatic logic [AW-1:0] exp_addr();
        logic [AW-1:0] a;
        a = '0;
        a[19:16] = 4'b0011;
        return a;
    endfunction

    function automatic logic [DW-1:0] exp_data(input logic [2:0] m);
        logic [DW-1:0] d;
        d = '0;
        d[2:0] = m;
        return d;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_idle_bus(input string tag);
        check({tag, " strobe"}, 64'(cyc_strobe), 0);
        check({tag, " ack"},    64'(cyc_ack), 0);
        check({tag, " write"},  64'(cyc_write), 0);
    endtask

    // Full entry: drives the request, bus grant and optional halt, checks every cycle
    task automatic run_entry(input logic [2:0] m, input int wait_n,
                             input bit do_halt, input int hold_n);
        @(negedge clk);
        halt = do_halt; mask_lvl = ~m; stop_req = 1'b1; bus_free = 1'b0;
        @(negedge clk);
        stop_req = 1'b0;
        check_idle_bus("R2 wait");
        check("R2 stopped", 64'(stopped), 0);
        for (int i = 0; i < wait_n; i++) begin
            @(negedge clk);
            check_idle_bus("R2 bus busy");
        end
        bus_free = 1'b1; mask_lvl = m;
        @(negedge clk);
        bus_free = 1'b0; mask_lvl = ~m;
        for (int i = 0; i < LEN; i++) begin
            check("R3 strobe", 64'(cyc_strobe), 1);
            check("R3 write",  64'(cyc_write), 1);
            check("R3 fc",     64'(cyc_fc), 64'(3'b111));
            check("R3 addr",   64'(cyc_addr), 64'(exp_addr()));
            check("R4 data",   64'(cyc_data), 64'(exp_data(m)));
            check("R5 ack",    64'(cyc_ack), (i == LEN - 1) ? 1 : 0);
            @(negedge clk);
        end
        check_idle_bus("R5 after cycle");
        if (!do_halt) begin
            check("R7 stopped", 64'(stopped), 1);
        end else begin
            check("R6 held", 64'(stopped), 0);
            for (int i = 0; i < hold_n; i++) begin
                @(negedge clk);
                check("R6 held", 64'(stopped), 0);
            end
            halt = 1'b0;
            @(negedge clk); check("R6 edge1", 64'(stopped), 0);
            @(negedge clk); check("R6 edge2", 64'(stopped), 0);
            @(negedge clk); check("R6 edge3", 64'(stopped), 1);
        end
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check("R8 stays", 64'(stopped), 1);
        check_idle_bus("R8 bus");
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        check("R9 wake", 64'(stopped), 0);
        @(negedge clk);
        check_idle_bus("R8 idle after wake");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1CE5));
        rst = 1'b1; stop_req = 1'b0; bus_free = 1'b0; halt = 1'b0;
        wake = 1'b0; mask_lvl = 3'd0;
        repeat (3) @(negedge clk);
        check_idle_bus("R1 in reset");
        check("R1 stopped", 64'(stopped), 0);
        rst = 1'b0;
        @(negedge clk);
        check_idle_bus("R1 after reset");
        check("R1 addr", 64'(cyc_addr), 0);
        check("R1 data", 64'(cyc_data), 0);
        check("R1 fc",   64'(cyc_fc), 0);

        // Directed corners
        run_entry(3'd7, 0, 1'b0, 0);
        run_entry(3'd0, 3, 1'b1, 0);
        run_entry(3'd5, 1, 1'b1, 6);

        // R9: wake while waiting for the bus is ignored
        @(negedge clk);
        stop_req = 1'b1; mask_lvl = 3'd2;
        @(negedge clk);
        stop_req = 1'b0; wake = 1'b1;
        @(negedge clk);
        wake = 1'b0; bus_free = 1'b1;
        @(negedge clk);
        bus_free = 1'b0;
        check("R9 wake ignored", 64'(cyc_strobe), 1);
        check("R4 data", 64'(cyc_data), 64'(exp_data(3'd2)));

        // R10: reset in the middle of the cycle
        rst = 1'b1;
        @(negedge clk);
        check_idle_bus("R10 reset mid-cycle");
        check("R10 stopped", 64'(stopped), 0);
        rst = 1'b0;
        @(negedge clk);
        run_entry(3'd6, 2, 1'b0, 0);

        // Random mix
        for (int k = 0; k < 40; k++) begin
            run_entry(3'($urandom_range(0, 7)), int'($urandom_range(0, 5)),
                      1'($urandom_range(0, 1)), int'($urandom_range(0, 4)));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule